// File: doc/BRIEF.md
# Shared-Line Stereo Serial Sample Transmitter

This block sends one 16-bit two's-complement audio sample per half-frame on a single serial data line. Two external clocks, a bit clock and a left/right word clock, set the timing. Both clocks are sampled in the block's own system clock domain. The block moves one bit on each falling edge of the bit clock. A static channel-select pin chooses which half of the word clock this unit owns. During the other half the data line is released: the output enable goes low and the data pin is held low. Two identical mono units can therefore share one line, one wired as the high-half unit and one as the low-half unit.

A format pin chooses between two framings. In the MSB-aligned framing the first bit of a word goes out with the word-clock change. In the I2S-style framing the first bit goes out one bit period later, and the enable window moves with it. Samples enter through a valid/ready stream port into a one-entry holding register. The holding register is emptied into the shift register when the unit's own half-frame starts. If no fresh sample is waiting at that moment, the previous word is sent again and a status flag reports the underrun. A synchronous clear, active high, returns every register to its idle value. One clear is needed after power-up.

Back-pressure on the sample port works as follows. `s_ready` is high only while the holding register is empty. A word is taken on a clock edge where `s_valid` and `s_ready` are both high. After that, `s_ready` stays low until the next start of an own half-frame moves the word into the shift register. A source that holds `s_valid` high while `s_ready` is low loses nothing, because its word is simply not taken.

Top module: `sstx_top`

## Requirements
- R1: The word is shifted out most significant bit first, one bit per bit-clock falling edge. The word clock level and the bit clock are both sampled by the system clock. A falling edge is a sampled 1 followed by a sampled 0.
- R2: With `chan_sel`=1 the unit drives only during the half where the word clock sampled at the falling edge is 1. With `chan_sel`=0 it drives only during the half where it is 0. Outside its window, `sd_oe`=0 and `sd_o`=0.
- R3: With `fmt_i2s`=0 the MSB is presented at the first falling edge where the sampled word clock has changed to the unit's own level. The enable covers exactly the falling edges of that half.
- R4: With `fmt_i2s`=1 the MSB is presented one falling edge after the own-level change, and the enable window starts there. With 16 bit periods per half, the LSB is presented at the first falling edge of the following half.
- R5: If a half-frame has more than 16 bit periods, the bits after the LSB are driven as 0 while `sd_oe` stays 1.
- R6: `s_ready` is 1 exactly when the holding register is empty. A word is taken on `s_valid`&&`s_ready`, and a word offered while `s_ready`=0 is never transmitted.
- R7: A word taken during the unit's own half-frame does not change the word being shifted. It is sent from the next own half-frame on.
- R8: At each start of an own half-frame without a waiting word, the previously sent word is repeated and `underrun` becomes 1. At a start with a waiting word, `underrun` becomes 0.
- R9: While `clr` is 1, on the next clock: `sd_oe`=0, `sd_o`=0, `s_ready`=1, `underrun`=0, and the remembered previous word becomes 0.
- R10: `sd_o` and `sd_oe` change only on system clock edges where a bit-clock falling edge is seen, or where `clr` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples both serial clocks |
| clr | input | 1 | Synchronous clear, active high |
| bclk | input | 1 | Bit clock; bits advance on its falling edge |
| lrclk | input | 1 | Left/right word clock |
| chan_sel | input | 1 | Static: 1 = own the word-clock-high half, 0 = own the low half |
| fmt_i2s | input | 1 | Static: 1 = one-bit-delayed framing, 0 = MSB-aligned framing |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (holding register empty) |
| s_data | input | 16 | Sample, two's complement |
| sd_o | output | 1 | Serial data, low while released |
| sd_oe | output | 1 | Output enable for the shared line |
| underrun | output | 1 | Last own half-frame repeated the previous word |

## Verification
The bench targets several corner cases, each paired with the failure it would expose. The one-slot shift of the I2S-style window checks that the LSB lands in the first slot of the other unit's half; a design that dropped the delay would cut the LSB and start the MSB one slot early. Over-long half-frames check zero padding; a design without it would shift out stale ones or release the line too soon. A word offered while the holding register is full must never appear, and a word taken mid-transmission must not corrupt the word in flight. A design that overwrote the hold or reloaded the shifter early would show a wrong bit pattern. Underrun repetition and a clear in the middle of a half-frame check that the line goes quiet at once and that the repeated word after the clear is zero.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  // Events derived at one system clock edge from the sampled serial clocks.
  typedef struct packed {
    logic tick;    // bit-clock falling edge seen this cycle
    logic start;   // own transmit window opens at this tick
    logic active;  // this tick lies inside the own transmit window
  } slot_ev_t;
endpackage

// File: rtl/sstx_framer.sv
module sstx_framer
  import sstx_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     bclk,
  input  logic     lrclk,
  input  logic     chan_sel,
  input  logic     fmt_i2s,
  output slot_ev_t ev
);
  localparam int HIST = 2;

  logic            bclk_q;
  logic [HIST-1:0] lr_hist;   // [0] = level at last tick, [1] = tick before
  logic            win_new;
  logic            win_old;

  always_ff @(posedge clk) begin
    if (clr) begin
      bclk_q  <= 1'b0;
      lr_hist <= '0;
    end else begin
      bclk_q <= bclk;
      if (ev.tick) lr_hist <= {lr_hist[HIST-2:0], lrclk};
    end
  end

  // Window level: current level for aligned framing, one tick late otherwise.
  always_comb begin
    if (fmt_i2s) begin
      win_new = lr_hist[0];
      win_old = lr_hist[1];
    end else begin
      win_new = lrclk;
      win_old = lr_hist[0];
    end
    ev.tick   = bclk_q & ~bclk;
    ev.active = ev.tick & (win_new == chan_sel);
    ev.start  = ev.active & (win_old != chan_sel);
  end
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              take,
  output logic [WORD_W-1:0] word_o,
  output logic              underrun
);
  logic              full;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] last_q;
  logic              accept;

  assign s_ready = ~full;
  assign accept  = s_valid & ~full;
  assign word_o  = full ? hold_q : last_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      full     <= 1'b0;
      hold_q   <= '0;
      last_q   <= '0;
      underrun <= 1'b0;
    end else begin
      if (take) begin
        last_q   <= word_o;
        underrun <= ~full;
        full     <= 1'b0;
      end
      if (accept) begin
        hold_q <= s_data;
        full   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  slot_ev_t          ev,
  input  logic [WORD_W-1:0] word_i,
  output logic              sd_o,
  output logic              sd_oe
);
  logic [WORD_W-1:0] sh_q;
  logic              armed;

  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q  <= '0;
      armed <= 1'b0;
      sd_oe <= 1'b0;
    end else if (ev.tick) begin
      if (ev.start) begin
        sh_q  <= word_i;
        armed <= 1'b1;
        sd_oe <= 1'b1;
      end else if (ev.active) begin
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        sd_oe <= armed;
      end else begin
        sd_oe <= 1'b0;
      end
    end
  end

  assign sd_o = sd_oe & sh_q[WORD_W-1];
endmodule

// File: rtl/sstx_top.sv
module sstx_top
  import sstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              chan_sel,
  input  logic              fmt_i2s,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              sd_o,
  output logic              sd_oe,
  output logic              underrun
);
  slot_ev_t          ev;
  logic [WORD_W-1:0] next_word;

  sstx_framer u_framer (
    .clk      (clk),
    .clr      (clr),
    .bclk     (bclk),
    .lrclk    (lrclk),
    .chan_sel (chan_sel),
    .fmt_i2s  (fmt_i2s),
    .ev       (ev)
  );

  sstx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .clr      (clr),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .take     (ev.start),
    .word_o   (next_word),
    .underrun (underrun)
  );

  sstx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .clr    (clr),
    .ev     (ev),
    .word_i (next_word),
    .sd_o   (sd_o),
    .sd_oe  (sd_oe)
  );
endmodule

// File: rtl/sstx_checks.sv
module sstx_checks (
  input logic clk,
  input logic clr,
  input logic bclk,
  input logic lrclk,
  input logic chan_sel,
  input logic fmt_i2s,
  input logic s_valid,
  input logic s_ready,
  input logic sd_o,
  input logic sd_oe,
  input logic underrun
);
  logic b_prev;
  logic lr_t1;
  logic lr_t2;
  logic fall;

  assign fall = b_prev & ~bclk;

  always_ff @(posedge clk) begin
    if (clr) begin
      b_prev <= 1'b0;
      lr_t1  <= 1'b0;
      lr_t2  <= 1'b0;
    end else begin
      b_prev <= bclk;
      if (fall) begin
        lr_t1 <= lrclk;
        lr_t2 <= lr_t1;
      end
    end
  end

  assert_aligned_window_R3: assert property (@(posedge clk) disable iff (clr)
    (!fmt_i2s && sd_oe) |-> (lr_t1 == chan_sel));

  assert_delayed_window_R4: assert property (@(posedge clk) disable iff (clr)
    (fmt_i2s && sd_oe) |-> (lr_t2 == chan_sel));

  assert_accept_fills_R6: assert property (@(posedge clk) disable iff (clr)
    (s_valid && s_ready) |=> !s_ready);

  assert_clear_idle_R9: assert property (@(posedge clk)
    clr |=> (!sd_oe && !sd_o && s_ready && !underrun));

  assert_tick_only_R10: assert property (@(posedge clk) disable iff (clr)
    !fall |=> ($stable(sd_o) && $stable(sd_oe)));
endmodule

bind sstx_top sstx_checks u_checks (
  .clk      (clk),
  .clr      (clr),
  .bclk     (bclk),
  .lrclk    (lrclk),
  .chan_sel (chan_sel),
  .fmt_i2s  (fmt_i2s),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .sd_o     (sd_o),
  .sd_oe    (sd_oe),
  .underrun (underrun)
);

// File: tb/tb_sstx_top.sv
module tb_sstx_top;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        chan_sel = 1'b1;
  logic        fmt_i2s = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        sd_o;
  logic        sd_oe;
  logic        underrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sstx_top dut (
    .clk(clk), .clr(clr), .bclk(bclk), .lrclk(lrclk),
    .chan_sel(chan_sel), .fmt_i2s(fmt_i2s),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sd_o(sd_o), .sd_oe(sd_oe), .underrun(underrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear(input logic ch, input logic fmt);
    @(negedge clk);
    clr = 1'b1; chan_sel = ch; fmt_i2s = fmt; bclk = 1'b1; lrclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  function automatic logic bit_of(input logic [15:0] w, input int idx);
    return (idx < 16) ? w[15-idx] : 1'b0;
  endfunction

  // One half-frame of n bit periods with word clock level lr.
  task automatic play_half(input logic lr, input int n, input bit own,
                           input logic [15:0] w, input bit carry_en,
                           input logic [15:0] carry_w, input int carry_n,
                           input int push_at, input logic [15:0] push_w);
    for (int j = 0; j < n; j++) begin
      logic e_oe;
      logic e_sd;
      logic s_sd;
      logic s_oe;
      @(negedge clk);
      bclk = 1'b0; lrclk = lr;
      @(negedge clk);
      if (!fmt_i2s) begin
        e_oe = own;
        e_sd = own ? bit_of(w, j) : 1'b0;
      end else if (own) begin
        e_oe = (j != 0);
        e_sd = (j != 0) ? bit_of(w, j - 1) : 1'b0;
      end else begin
        e_oe = (j == 0) && carry_en;
        e_sd = e_oe ? bit_of(carry_w, carry_n - 1) : 1'b0;
      end
      // R1 R2 R3 R4 R5: per-slot enable and data
      check(own ? "R1/R2 own-slot oe" : "R2 other-slot oe", int'(sd_oe), int'(e_oe));
      check(j >= 16 ? "R5 pad bit" : "R1 data bit", int'(sd_o), int'(e_sd));
      s_sd = sd_o; s_oe = sd_oe;
      bclk = 1'b1;
      @(negedge clk);
      // R10: no change while the bit clock stays high
      check("R10 hold between ticks", int'({s_oe, s_sd}), int'({sd_oe, sd_o}));
      if (j == push_at) push(push_w);
    end
  endtask

  task automatic t_reset;
    do_clear(1'b1, 1'b0);
    check("R9 reset oe", int'(sd_oe), 0);
    check("R9 reset sd", int'(sd_o), 0);
    check("R9 reset ready", int'(s_ready), 1);
    check("R9 reset underrun", int'(underrun), 0);
  endtask

  task automatic t_aligned_high;
    do_clear(1'b1, 1'b0);
    push(16'hA5C3);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'hA5C3, 0, '0, 16, -1, '0);
    check("R8 fresh word no underrun", int'(underrun), 0);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
  endtask

  task automatic t_aligned_low_pad;
    do_clear(1'b0, 1'b0);
    push(16'hFFFF);
    play_half(1'b1, 20, 0, '0, 0, '0, 20, -1, '0);
    play_half(1'b0, 20, 1, 16'hFFFF, 0, '0, 20, -1, '0);
    play_half(1'b1, 20, 0, '0, 0, '0, 20, -1, '0);
  endtask

  task automatic t_i2s;
    do_clear(1'b1, 1'b1);
    push(16'h8001);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h8001, 0, '0, 16, -1, '0);
    // R4: LSB appears in the first slot of the other half
    play_half(1'b0, 16, 0, '0, 1, 16'h8001, 16, -1, '0);
    do_clear(1'b0, 1'b1);
    push(16'h6D2B);
    play_half(1'b1, 18, 0, '0, 0, '0, 18, -1, '0);
    play_half(1'b0, 18, 1, 16'h6D2B, 0, '0, 18, -1, '0);
    play_half(1'b1, 18, 0, '0, 1, 16'h6D2B, 18, -1, '0);
  endtask

  task automatic t_underrun;
    do_clear(1'b1, 1'b0);
    push(16'h1234);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h1234, 0, '0, 16, -1, '0);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h1234, 0, '0, 16, -1, '0);
    check("R8 repeat sets underrun", int'(underrun), 1);
    push(16'h4321);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h4321, 0, '0, 16, -1, '0);
    check("R8 fresh word clears underrun", int'(underrun), 0);
  endtask

  task automatic t_backpressure;
    do_clear(1'b1, 1'b0);
    push(16'hC0DE);
    check("R6 ready low when full", int'(s_ready), 0);
    push(16'hDEAD);
    check("R6 ready stays low", int'(s_ready), 0);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    // R7: word taken at slot 5 must not disturb the word in flight
    play_half(1'b1, 16, 1, 16'hC0DE, 0, '0, 16, 5, 16'h5A0F);
    check("R6 ready low after mid-half take", int'(s_ready), 0);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h5A0F, 0, '0, 16, -1, '0);
    check("R6 ready after start consumed", int'(s_ready), 1);
    check("R7 queued word no underrun", int'(underrun), 0);
  endtask

  task automatic t_clear_mid;
    do_clear(1'b1, 1'b0);
    push(16'hFFFF);
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 5, 1, 16'hFFFF, 0, '0, 16, -1, '0);
    push(16'h7777);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R9 mid clear oe", int'(sd_oe), 0);
    check("R9 mid clear sd", int'(sd_o), 0);
    check("R9 mid clear ready", int'(s_ready), 1);
    check("R9 mid clear underrun", int'(underrun), 0);
    // previous word is zero after the clear
    play_half(1'b0, 16, 0, '0, 0, '0, 16, -1, '0);
    play_half(1'b1, 16, 1, 16'h0000, 0, '0, 16, -1, '0);
    check("R9 R8 zero repeat after clear", int'(underrun), 1);
  endtask

  initial begin
    t_reset();
    t_aligned_high();
    t_aligned_low_pad();
    t_i2s();
    t_underrun();
    t_backpressure();
    t_clear_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule